// File: doc/BRIEF.md
# Dual-Bank Seven-to-One Lane Deserializer

This block turns ten serial data lanes back into parallel pixel words. The lanes form two banks of five, odd and even. Each lane carries seven bits per pixel period, and the block runs on a bit clock at seven times the pixel rate. A one-cycle frame marker, sampled on the bit clock, marks the first bit of every seven-bit slot. At each frame boundary every bank yields a 35-bit word, so the block delivers 70 bits per pixel period.

The words leave through a fixed four-pixel-period pipeline. Each bank has its own enable, so the block can run with both banks (dual-pixel) or with one bank (single-pixel). An active-low power-down input blanks all data outputs. After power-down is released, or after reset, the outputs stay blank until the pipeline holds only complete slots. A strobe-select input picks whether downstream logic latches the data on the rising or the falling edge of the pixel clock output. Either way, that edge falls in the middle of the word.

Top module: `dual_bank_deser`

## Requirements
- R1: A slot begins on the bit-clock cycle in which frame_i is sampled high. The marker is high for that one cycle in every seven. Within each lane, the first bit of the slot becomes the most significant bit of its 7-bit field.
- R2: Lane n of a bank (n = 0..4) fills bits [7n+6:7n] of that bank's word. odd_lanes_i feeds odd_word_o and even_lanes_i feeds even_word_o.
- R3: The slot that begins at frame edge k appears on the outputs right after frame edge k+4. It holds, unchanged, until frame edge k+5.
- R4: With odd_en_i low, odd_word_o is all zeros in the same cycle. even_word_o is unaffected, which gives single-pixel operation.
- R5: With even_en_i low, even_word_o is all zeros in the same cycle. odd_word_o is unaffected.
- R6: While pd_ni is low, both words and pix_clk_o are low.
- R7: After reset, or after pd_ni returns high, both words stay zero up to the fifth frame edge sampled with pd_ni high. The first word shown is the first slot that began after the release.
- R8: With strobe_rise_i high, pix_clk_o is low during bit phases 0-2 after a frame edge and high during phases 3-6. Its rising edge therefore sits mid-word.
- R9: With strobe_rise_i low, pix_clk_o is the inverse of the R8 waveform. Its falling edge therefore sits mid-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | High on the first bit of each slot |
| odd_lanes_i | input | 5 | Serial lanes of the odd bank |
| even_lanes_i | input | 5 | Serial lanes of the even bank |
| odd_en_i | input | 1 | Odd bank output enable |
| even_en_i | input | 1 | Even bank output enable |
| pd_ni | input | 1 | Power-down, active low |
| strobe_rise_i | input | 1 | 1: rising-edge strobe, 0: falling-edge strobe |
| odd_word_o | output | 35 | Odd bank parallel word |
| even_word_o | output | 35 | Even bank parallel word |
| pix_clk_o | output | 1 | Pixel clock output |

## Verification
The hardest case to reach is a power-down that starts and ends in the middle of a slot. In that case the pipeline still holds a slot that began before the release, and that slot must never show. The driver drops and raises pd_ni at chosen bit positions inside a slot. The scoreboard then counts frame edges seen with pd_ni high, so that it can predict exactly which slot is the first one allowed through. The patterns include single-bit and walking-lane words, so that a reversed bit order or a swapped lane field shows up as a mismatch.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int unsigned NUM_BANKS   = 2;
  localparam int unsigned DEF_LANES   = 5;
  localparam int unsigned DEF_SLOT    = 7;
  localparam int unsigned DEF_LAT_PIX = 4;

  typedef enum logic {
    BANK_ODD  = 1'b0,
    BANK_EVEN = 1'b1
  } bank_e;
endpackage

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int unsigned LANES = 5,
  parameter int unsigned SLOT  = 7,
  localparam int unsigned BW   = LANES * SLOT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [LANES-1:0] lanes_i,
  output logic [BW-1:0]    word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLOT-1:0] sh_q;
    logic [SLOT-1:0] cap_q;

    // first bit of the slot ends up in the MSB
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q  <= '0;
        cap_q <= '0;
      end else begin
        sh_q <= {sh_q[SLOT-2:0], lanes_i[g]};
        if (frame_i) cap_q <= sh_q;
      end
    end

    assign word_o[g*SLOT +: SLOT] = cap_q;
  end
endmodule

// File: rtl/frame_delay.sv
module frame_delay #(
  parameter int unsigned W     = 35,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] stg_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      end else if (adv_i) begin
        stg_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
      end
    end

    assign q_o = stg_q[DEPTH-1];

    // R3
    hold_between_frames_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(q_o));
  end
endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl #(
  parameter int unsigned SLOT    = 7,
  parameter int unsigned LAT_PIX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic pd_ni,
  input  logic strobe_rise_i,
  output logic ready_o,
  output logic pix_clk_o
);
  localparam int unsigned PW = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam int unsigned CW = $clog2(LAT_PIX + 2);
  localparam logic [PW-1:0] PH_LAST = PW'(SLOT - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(SLOT / 2);
  localparam logic [CW-1:0] CNT_RDY = CW'(LAT_PIX + 1);

  logic [PW-1:0] ph_q;
  logic [CW-1:0] cnt_q;
  logic          pix_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= '0;
    else if (frame_i)          ph_q <= '0;
    else if (ph_q == PH_LAST)  ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end

  // frames seen since power-up; first marker opens a slot, later ones close slots
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!pd_ni)                     cnt_q <= '0;
    else if (frame_i && cnt_q != CNT_RDY) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o   = (cnt_q == CNT_RDY);
  assign pix_int   = (ph_q >= PH_MID);
  assign pix_clk_o = pd_ni & (strobe_rise_i ? pix_int : ~pix_int);

  // R6
  pd_clears_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !ready_o);

  // R7
  ready_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(frame_i) && $past(pd_ni)));

  // R8, R9
  strobe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (pix_clk_o == (pd_ni && !strobe_rise_i)));
endmodule

// File: rtl/dual_bank_deser.sv
module dual_bank_deser
  import deser_pkg::*;
#(
  parameter int unsigned LANES   = DEF_LANES,
  parameter int unsigned SLOT    = DEF_SLOT,
  parameter int unsigned LAT_PIX = DEF_LAT_PIX,
  localparam int unsigned BW     = LANES * SLOT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [LANES-1:0] odd_lanes_i,
  input  logic [LANES-1:0] even_lanes_i,
  input  logic             odd_en_i,
  input  logic             even_en_i,
  input  logic             pd_ni,
  input  logic             strobe_rise_i,
  output logic [BW-1:0]    odd_word_o,
  output logic [BW-1:0]    even_word_o,
  output logic             pix_clk_o
);
  localparam int unsigned DLY = (LAT_PIX > 0) ? LAT_PIX - 1 : 0;

  logic [LANES-1:0]     lanes_a [NUM_BANKS];
  logic [BW-1:0]        cap_w   [NUM_BANKS];
  logic [BW-1:0]        dly_w   [NUM_BANKS];
  logic [BW-1:0]        word_w  [NUM_BANKS];
  logic [NUM_BANKS-1:0] en_a;
  logic                 ready;

  assign lanes_a[BANK_ODD]  = odd_lanes_i;
  assign lanes_a[BANK_EVEN] = even_lanes_i;
  assign en_a[BANK_ODD]     = odd_en_i;
  assign en_a[BANK_EVEN]    = even_en_i;

  deser_ctrl #(.SLOT(SLOT), .LAT_PIX(LAT_PIX)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_i       (frame_i),
    .pd_ni         (pd_ni),
    .strobe_rise_i (strobe_rise_i),
    .ready_o       (ready),
    .pix_clk_o     (pix_clk_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lane_bank #(.LANES(LANES), .SLOT(SLOT)) u_lanes (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i),
      .lanes_i (lanes_a[b]),
      .word_o  (cap_w[b])
    );

    frame_delay #(.W(BW), .DEPTH(DLY)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (frame_i),
      .d_i    (cap_w[b]),
      .q_o    (dly_w[b])
    );

    assign word_w[b] = dly_w[b] & {BW{en_a[b] & pd_ni & ready}};
  end

  assign odd_word_o  = word_w[BANK_ODD];
  assign even_word_o = word_w[BANK_EVEN];

  // R3
  odd_word_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(frame_i) && $past(odd_en_i) && odd_en_i && $past(pd_ni) && pd_ni)
      |-> $stable(odd_word_o));

  // R4, R5
  bank_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(frame_i) && $stable(even_en_i) && $stable(pd_ni) && $changed(odd_en_i))
      |-> $stable(even_word_o));
endmodule

// File: tb/dual_bank_deser_bench.sv
module dual_bank_deser_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic [4:0]  odd_lanes_i = '0;
  logic [4:0]  even_lanes_i = '0;
  logic        odd_en_i = 1'b1;
  logic        even_en_i = 1'b1;
  logic        pd_ni = 1'b1;
  logic        strobe_rise_i = 1'b1;
  logic [34:0] odd_word_o;
  logic [34:0] even_word_o;
  logic        pix_clk_o;

  always #2 clk = ~clk;

  dual_bank_deser u_dual_bank_deser (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i),
    .odd_lanes_i(odd_lanes_i), .even_lanes_i(even_lanes_i),
    .odd_en_i(odd_en_i), .even_en_i(even_en_i), .pd_ni(pd_ni),
    .strobe_rise_i(strobe_rise_i), .odd_word_o(odd_word_o),
    .even_word_o(even_word_o), .pix_clk_o(pix_clk_o)
  );

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [69:0] exp_q[$];
  logic [69:0] exp_cur = '0;
  int          frames_b = 0;
  int          ph_b = 0;
  string       data_tag = "R3";

  task automatic check(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
    end
  endtask

  // driver: one slot, MSB first, optional pd change at a bit position
  task automatic send_slot(input logic [34:0] ow, input logic [34:0] ew,
                           input int pd_bit = -1, input bit pd_val = 1'b1);
    for (int b = 0; b < 7; b++) begin
      @(negedge clk);
      frame_i = (b == 0);
      for (int l = 0; l < 5; l++) begin
        odd_lanes_i[l]  = ow[7*l + 6 - b];
        even_lanes_i[l] = ew[7*l + 6 - b];
      end
      if (b == pd_bit) pd_ni = pd_val;
      if (b == 0) exp_q.push_back({ow, ew});
    end
  endtask

  function automatic logic [34:0] rnd35();
    return 35'({$urandom(), $urandom()});
  endfunction

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      bit rdy;
      logic [34:0] eo, ee;
      bit ec;
      string to, te, tc;
      if (!pd_ni) frames_b = 0;
      else if (frame_i && frames_b < 5) frames_b++;
      if (frame_i) begin
        ph_b = 0;
        if (exp_q.size() > 4) exp_cur = exp_q.pop_front();
      end else begin
        ph_b = (ph_b == 6) ? 0 : ph_b + 1;
      end
      rdy = (frames_b >= 5);
      eo = (pd_ni && rdy && odd_en_i)  ? exp_cur[69:35] : '0;
      ee = (pd_ni && rdy && even_en_i) ? exp_cur[34:0]  : '0;
      to = !pd_ni ? "R6" : !rdy ? "R7" : !odd_en_i  ? "R4" : data_tag;
      te = !pd_ni ? "R6" : !rdy ? "R7" : !even_en_i ? "R5" : data_tag;
      check(odd_word_o == eo, {to, " odd word"}, odd_word_o, eo);
      check(even_word_o == ee, {te, " even word"}, even_word_o, ee);
      ec = pd_ni && (strobe_rise_i ? (ph_b >= 3) : (ph_b < 3));
      tc = !pd_ni ? "R6" : strobe_rise_i ? "R8" : "R9";
      check(pix_clk_o == ec, {tc, " pix clock"}, 35'(pix_clk_o), 35'(ec));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired at %0t: got hang expected completion", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: outputs low (R7)
    check(odd_word_o == '0, "R7 reset odd", odd_word_o, '0);
    check(even_word_o == '0, "R7 reset even", even_word_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: single first bit per lane, then last bit only
    data_tag = "R1";
    for (int i = 0; i < 6; i++) send_slot(35'h408_1020_40 >> 0, 35'h1_0204_081);
    send_slot(35'h408102040, 35'h001020408);
    send_slot(35'h1, 35'h40);
    // R2: walking lane identifiers
    data_tag = "R2";
    for (int l = 0; l < 5; l++) send_slot(35'(7'(l + 1)) << (7 * l), 35'(7'(7'h70 | l)) << (7 * l));
    for (int l = 0; l < 5; l++) send_slot(~(35'h7f << (7 * l)), 35'h7f << (7 * l));
    // R3: random data
    data_tag = "R3";
    for (int i = 0; i < 12; i++) send_slot(rnd35(), rnd35());
    // R4: odd bank off (single-pixel)
    odd_en_i = 1'b0;
    for (int i = 0; i < 8; i++) send_slot(rnd35(), rnd35());
    odd_en_i = 1'b1;
    // R5: even bank off
    even_en_i = 1'b0;
    for (int i = 0; i < 8; i++) send_slot(rnd35(), rnd35());
    even_en_i = 1'b1;
    // R9: falling-edge strobe
    strobe_rise_i = 1'b0;
    for (int i = 0; i < 6; i++) send_slot(rnd35(), rnd35());
    strobe_rise_i = 1'b1;
    // R6, R7: power-down entered and left mid-slot
    send_slot(rnd35(), rnd35(), 3, 1'b0);
    for (int i = 0; i < 3; i++) send_slot(rnd35(), rnd35());
    send_slot(rnd35(), rnd35(), 4, 1'b1);
    for (int i = 0; i < 10; i++) send_slot(rnd35(), rnd35());
    // R6 with falling strobe, released exactly on a frame bit
    strobe_rise_i = 1'b0;
    send_slot(rnd35(), rnd35(), 1, 1'b0);
    send_slot(rnd35(), rnd35(), 0, 1'b1);
    for (int i = 0; i < 8; i++) send_slot(rnd35(), rnd35());
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule